// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a synchronous serial slave that lets a host read and write a bank of 32 byte-wide registers. Every transaction opens with an 8-bit instruction byte. The instruction selects a register, picks a one-byte or two-byte transfer, and says whether the host reads or writes. The data bytes follow that byte. Bits travel least significant first.

The serial clock and chip select are sampled in the system clock domain. The block acts on edges of the sampled serial clock. A static input picks which serial clock edge is active: rising or falling. Input bits are taken on the active edge. Read data is launched on the opposite, inactive edge, so the host can sample it on the next active edge.

In four-wire mode, read data leaves on a dedicated output. In two-wire mode, the data input line is turned around and also carries the read data. It is released after the final bit. A two-byte access reaches the register paired with the addressed one:
- an odd address steps down by one;
- an even address steps up by one.

When the last data byte ends, the slave waits for a new instruction byte. Chip select does not have to toggle between transactions.

Top module: `sra_serial_slave`

## Requirements
- R1: The instruction byte is taken least significant bit first on eight active edges after chip select falls. Bits 4..0 are the register address. Bit 5 selects the word length (0 = one byte, 1 = two bytes). Bit 6 is 1 for a read and 0 for a write. Bit 7 is sent as 0.
- R2: In a write, each data byte is stored in its register on the eighth active edge of that byte.
- R3: In a read, the data leaves least significant bit first. Bit 0 of a byte is driven on the inactive edge before the first active edge of that byte. Each later bit is driven on the inactive edge that follows the previous active edge. The output changes only on inactive edges.
- R4: In a two-byte access, the second byte uses address − 1 when the instruction address is odd and address + 1 when it is even. This holds at both ends of the address range: 31 pairs with 30, and 0 pairs with 1.
- R5: `dout_oe` is high one clock after `cs_n` goes low and low one clock after `cs_n` goes high.
- R6: In two-wire mode, `din_oe` rises on the inactive edge that launches the first read bit. It falls on the inactive edge that follows the final active edge of the read, or when `cs_n` goes high. `din_o` carries the read bits. In four-wire mode, `din_oe` stays low.
- R7: `cfg_rise_active` = 1 makes the rising edge active. `cfg_rise_active` = 0 makes the falling edge active. The inactive edge is always the other one.
- R8: After the final data byte, the next eight active edges are taken as a new instruction byte, with chip select held low.
- R9: Raising `cs_n` in the middle of a transfer aborts it. A partly shifted write byte is not stored, and the next transaction starts at instruction bit 0.
- R10: After reset, every register reads as zero, and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rise_active | input | 1 | 1: rising edge of `sclk` is active; 0: falling edge is active |
| cfg_two_wire | input | 1 | 1: read data is also driven on the data input line |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| din_i | input | 1 | Serial data input, as seen at the pad |
| din_o | output | 1 | Read data driven toward the data input pad |
| din_oe | output | 1 | Output enable for `din_o` |
| dout | output | 1 | Serial read data |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
The checker assumes that `cs_n`, `sclk` and `din_i` are already synchronous to `clk`. It also assumes that each level of `sclk` lasts at least two clock cycles. The configuration inputs may change only while chip select is high. Chip select may change only while `sclk` sits at its inactive level.

The bench meets these assumptions as follows:
- It drives every input on the falling edge of `clk`.
- It holds each `sclk` level for four cycles.
- It changes mode only between transactions, with `sclk` first parked at the new inactive level.
- It toggles chip select only after a completed bit period.

// File: rtl/sra_pkg.sv
package sra_pkg;
  typedef enum logic {
    PH_INSTR = 1'b0,
    PH_DATA  = 1'b1
  } phase_t;
endpackage

// File: rtl/sra_edge_det.sv
module sra_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic cfg_rise_active,
  output logic act_ev,
  output logic inact_ev
);
  logic sclk_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  always_comb begin
    rise     = sclk & ~sclk_q;
    fall     = ~sclk & sclk_q;
    act_ev   = ~cs_n & (cfg_rise_active ? rise : fall);
    inact_ev = ~cs_n & (cfg_rise_active ? fall : rise);
  end
endmodule

// File: rtl/sra_regbank.sv
module sra_regbank #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    logic sel;
    assign sel = wr_en && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= '0;
      else if (sel) mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sra_ctrl.sv
module sra_ctrl
  import sra_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              act_ev,
  input  logic              inact_ev,
  input  logic              din,
  input  logic              cfg_two_wire,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              dout,
  output logic              dout_oe,
  output logic              din_oe
);
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int WORD_B = ADDR_W;
  localparam int RD_B   = ADDR_W + 1;

  phase_t            phase_q,  phase_n;
  logic [CNT_W-1:0]  cnt_q,    cnt_n;
  logic [DATA_W-1:0] shreg_q,  shreg_n;
  logic [ADDR_W-1:0] addr_q,   addr_n;
  logic              word_q,   word_n;
  logic              rd_q,     rd_n;
  logic              second_q, second_n;
  logic              dout_q,   dout_n;
  logic              doe_q;
  logic              dinoe_q,  dinoe_n;
  logic              rel_q,    rel_n;

  logic [DATA_W-1:0] shifted;
  logic              last_bit;

  always_comb begin
    shifted  = {din, shreg_q[DATA_W-1:1]};
    last_bit = (cnt_q == CNT_W'(DATA_W - 1));

    phase_n  = phase_q;
    cnt_n    = cnt_q;
    shreg_n  = shreg_q;
    addr_n   = addr_q;
    word_n   = word_q;
    rd_n     = rd_q;
    second_n = second_q;
    dout_n   = dout_q;
    dinoe_n  = dinoe_q;
    rel_n    = rel_q;
    wr_en    = 1'b0;

    if (cs_n) begin
      phase_n  = PH_INSTR;
      cnt_n    = '0;
      second_n = 1'b0;
      dinoe_n  = 1'b0;
      rel_n    = 1'b0;
    end else if (act_ev) begin
      cnt_n = cnt_q + 1'b1;
      if (phase_q == PH_INSTR) begin
        shreg_n = shifted;
        if (last_bit) begin
          addr_n   = shifted[ADDR_W-1:0];
          word_n   = shifted[WORD_B];
          rd_n     = shifted[RD_B];
          phase_n  = PH_DATA;
          second_n = 1'b0;
          cnt_n    = '0;
        end
      end else begin
        if (rd_q) begin
          if (cnt_q == '0) shreg_n = rd_data;
        end else begin
          shreg_n = shifted;
          wr_en   = last_bit;
        end
        if (last_bit) begin
          cnt_n = '0;
          if (word_q && !second_q) begin
            second_n = 1'b1;
            addr_n   = {addr_q[ADDR_W-1:1], ~addr_q[0]};
          end else begin
            phase_n = PH_INSTR;
            rel_n   = rd_q;
          end
        end
      end
    end else if (inact_ev) begin
      if (phase_q == PH_DATA && rd_q) begin
        dout_n  = (cnt_q == '0) ? rd_data[0] : shreg_q[cnt_q];
        dinoe_n = cfg_two_wire;
      end
      if (rel_q) begin
        dinoe_n = 1'b0;
        rel_n   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_INSTR;
      cnt_q    <= '0;
      shreg_q  <= '0;
      addr_q   <= '0;
      word_q   <= 1'b0;
      rd_q     <= 1'b0;
      second_q <= 1'b0;
      dout_q   <= 1'b0;
      doe_q    <= 1'b0;
      dinoe_q  <= 1'b0;
      rel_q    <= 1'b0;
    end else begin
      phase_q  <= phase_n;
      cnt_q    <= cnt_n;
      shreg_q  <= shreg_n;
      addr_q   <= addr_n;
      word_q   <= word_n;
      rd_q     <= rd_n;
      second_q <= second_n;
      dout_q   <= dout_n;
      doe_q    <= ~cs_n;
      dinoe_q  <= dinoe_n;
      rel_q    <= rel_n;
    end
  end

  assign wr_addr = addr_q;
  assign wr_data = shifted;
  assign rd_addr = addr_q;
  assign dout    = dout_q;
  assign dout_oe = doe_q;
  assign din_oe  = dinoe_q;
endmodule

// File: rtl/sra_serial_slave.sv
module sra_serial_slave #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_rise_active,
  input  logic cfg_two_wire,
  input  logic cs_n,
  input  logic sclk,
  input  logic din_i,
  output logic din_o,
  output logic din_oe,
  output logic dout,
  output logic dout_oe
);
  logic              act_ev;
  logic              inact_ev;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  sra_edge_det i_edge (
    .clk             (clk),
    .rst_n           (rst_n),
    .cs_n            (cs_n),
    .sclk            (sclk),
    .cfg_rise_active (cfg_rise_active),
    .act_ev          (act_ev),
    .inact_ev        (inact_ev)
  );

  sra_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  sra_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .act_ev       (act_ev),
    .inact_ev     (inact_ev),
    .din          (din_i),
    .cfg_two_wire (cfg_two_wire),
    .rd_data      (rd_data),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_addr      (rd_addr),
    .dout         (dout),
    .dout_oe      (dout_oe),
    .din_oe       (din_oe)
  );

  assign din_o = dout;
endmodule

// File: rtl/sra_checker.sv
module sra_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_rise_active,
  input logic cfg_two_wire,
  input logic cs_n,
  input logic sclk,
  input logic dout,
  input logic dout_oe,
  input logic din_oe
);
  logic sclk_seen;
  logic inact_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_seen <= 1'b0;
    else        sclk_seen <= sclk;
  end

  assign inact_seen = !cs_n &&
    (cfg_rise_active ? (!sclk && sclk_seen) : (sclk && !sclk_seen));

  assert_dout_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !dout_oe);

  assert_dout_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> dout_oe);

  assert_four_wire_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_two_wire |-> !din_oe);

  assert_release_on_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !din_oe);

  assert_turn_on_inactive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(din_oe) |-> $past(inact_seen));

  assert_launch_inactive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && (dout != $past(dout))) |-> $past(inact_seen));
endmodule

bind sra_serial_slave sra_checker i_sra_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_rise_active (cfg_rise_active),
  .cfg_two_wire    (cfg_two_wire),
  .cs_n            (cs_n),
  .sclk            (sclk),
  .dout            (dout),
  .dout_oe         (dout_oe),
  .din_oe          (din_oe)
);

// File: tb/test_sra_serial_slave.sv
module test_sra_serial_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic clk;
  logic rst_n;
  logic cfg_rise_active;
  logic cfg_two_wire;
  logic cs_n;
  logic sclk;
  logic host_din;
  logic din_line;
  logic din_o;
  logic din_oe;
  logic dout;
  logic dout_oe;

  int checks;
  int errors;
  bit reported;

  assign din_line = din_oe ? din_o : host_din;

  sra_serial_slave i_sra_serial_slave (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_rise_active (cfg_rise_active),
    .cfg_two_wire    (cfg_two_wire),
    .cs_n            (cs_n),
    .sclk            (sclk),
    .din_i           (din_line),
    .din_o           (din_o),
    .din_oe          (din_oe),
    .dout            (dout),
    .dout_oe         (dout_oe)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ins(input logic rd, input logic word, input logic [4:0] a);
    return {1'b0, rd, word, a};
  endfunction

  task automatic set_mode(input logic rise, input logic two);
    @(negedge clk);
    cfg_rise_active = rise;
    cfg_two_wire    = two;
    sclk            = ~rise;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_on();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_off();
    @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic b, output logic rx, output logic oe_pre, output logic oe_post);
    host_din = b;
    repeat (HALF) @(negedge clk);
    rx     = cfg_two_wire ? din_line : dout;
    oe_pre = din_oe;
    sclk   = cfg_rise_active;
    repeat (HALF) @(negedge clk);
    oe_post = din_oe;
    sclk    = ~cfg_rise_active;
  endtask

  task automatic byte_io(input logic [7:0] tx, output logic [7:0] rx,
                         output logic oe_all, output logic oe_any, output logic oe_last);
    logic r, p, q;
    oe_all = 1'b1;
    oe_any = 1'b0;
    oe_last = 1'b0;
    for (int i = 0; i < 8; i++) begin
      bit_cycle(tx[i], r, p, q);
      rx[i]   = r;
      oe_all  = oe_all & p;
      oe_any  = oe_any | p | q;
      oe_last = q;
    end
  endtask

  task automatic do_write(input logic [4:0] a, input logic word,
                          input logic [7:0] d0, input logic [7:0] d1);
    logic [7:0] junk;
    logic x, y, z;
    byte_io(ins(1'b0, word, a), junk, x, y, z);
    byte_io(d0, junk, x, y, z);
    if (word) byte_io(d1, junk, x, y, z);
  endtask

  task automatic do_read(input logic [4:0] a, input logic word,
                         output logic [7:0] r0, output logic [7:0] r1,
                         output logic oe_all, output logic oe_any, output logic oe_last);
    logic [7:0] junk;
    logic x, y, z;
    r1 = 8'h00;
    byte_io(ins(1'b1, word, a), junk, x, y, z);
    byte_io(8'h00, r0, oe_all, oe_any, oe_last);
    if (word) begin
      byte_io(8'h00, r1, x, y, oe_last);
      oe_all = oe_all & x;
      oe_any = oe_any | y;
    end
  endtask

  task automatic t_reset();
    logic [7:0] r0, r1;
    logic a, b, c;
    chk("R10 dout_oe in reset", {15'b0, dout_oe}, 16'h0);
    chk("R10 din_oe in reset", {15'b0, din_oe}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cs_on();
    do_read(5'd5, 1'b0, r0, r1, a, b, c);
    chk("R10 register zero after reset", {8'h0, r0}, 16'h0000);
    do_read(5'd31, 1'b0, r0, r1, a, b, c);
    chk("R10 top register zero after reset", {8'h0, r0}, 16'h0000);
    cs_off();
  endtask

  task automatic t_single();
    logic [7:0] r0, r1;
    logic a, b, c;
    set_mode(1'b1, 1'b0);
    cs_on();
    chk("R5 dout_oe with select low", {15'b0, dout_oe}, 16'h1);
    do_write(5'd3, 1'b0, 8'h5A, 8'h00);
    do_read(5'd3, 1'b0, r0, r1, a, b, c);
    chk("R1 R2 R3 byte write then read", {8'h0, r0}, 16'h005A);
    chk("R6 four-wire din_oe quiet", {15'b0, b}, 16'h0);
    do_write(5'd17, 1'b0, 8'h81, 8'h00);
    do_read(5'd17, 1'b0, r0, r1, a, b, c);
    chk("R3 lsb-first pattern 81", {8'h0, r0}, 16'h0081);
    cs_off();
    chk("R5 dout_oe with select high", {15'b0, dout_oe}, 16'h0);
  endtask

  task automatic t_word();
    logic [7:0] r0, r1;
    logic a, b, c;
    set_mode(1'b1, 1'b0);
    cs_on();
    do_write(5'd6, 1'b1, 8'h11, 8'h22);
    do_read(5'd6, 1'b0, r0, r1, a, b, c);
    chk("R4 even word first byte", {8'h0, r0}, 16'h0011);
    do_read(5'd7, 1'b0, r0, r1, a, b, c);
    chk("R4 even word steps up", {8'h0, r0}, 16'h0022);
    do_write(5'd9, 1'b0, 8'h99, 8'h00);
    do_write(5'd8, 1'b0, 8'h88, 8'h00);
    do_read(5'd9, 1'b1, r0, r1, a, b, c);
    chk("R4 odd word read steps down", {r0, r1}, 16'h9988);
    do_write(5'd31, 1'b1, 8'hF1, 8'hE0);
    do_read(5'd30, 1'b0, r0, r1, a, b, c);
    chk("R4 address 31 pairs with 30", {8'h0, r0}, 16'h00E0);
    do_write(5'd0, 1'b1, 8'h0F, 8'hF0);
    do_read(5'd0, 1'b1, r0, r1, a, b, c);
    chk("R4 address 0 pairs with 1", {r0, r1}, 16'h0FF0);
    cs_off();
  endtask

  task automatic t_falling();
    logic [7:0] r0, r1;
    logic a, b, c;
    set_mode(1'b0, 1'b0);
    cs_on();
    do_write(5'd20, 1'b0, 8'hA5, 8'h00);
    do_read(5'd20, 1'b0, r0, r1, a, b, c);
    chk("R7 falling-active byte", {8'h0, r0}, 16'h00A5);
    do_read(5'd9, 1'b1, r0, r1, a, b, c);
    chk("R7 falling-active word", {r0, r1}, 16'h9988);
    cs_off();
  endtask

  task automatic t_two_wire();
    logic [7:0] r0, r1;
    logic a, b, c;
    set_mode(1'b1, 1'b1);
    cs_on();
    do_write(5'd14, 1'b0, 8'h3C, 8'h00);
    chk("R6 din_oe low during write", {15'b0, din_oe}, 16'h0);
    do_read(5'd14, 1'b0, r0, r1, a, b, c);
    chk("R6 two-wire read data", {8'h0, r0}, 16'h003C);
    chk("R6 din_oe held over data bits", {14'b0, a, c}, 16'h0003);
    repeat (HALF) @(negedge clk);
    chk("R6 din_oe released after final bit", {15'b0, din_oe}, 16'h0);
    chk("R5 dout_oe still high", {15'b0, dout_oe}, 16'h1);
    do_read(5'd6, 1'b1, r0, r1, a, b, c);
    chk("R6 two-wire word read", {r0, r1}, 16'h1122);
    chk("R6 din_oe over word", {14'b0, a, c}, 16'h0003);
    cs_off();
    set_mode(1'b0, 1'b1);
    cs_on();
    do_read(5'd20, 1'b0, r0, r1, a, b, c);
    chk("R6 R7 two-wire falling-active", {8'h0, r0}, 16'h00A5);
    repeat (HALF) @(negedge clk);
    chk("R6 release falling-active", {15'b0, din_oe}, 16'h0);
    cs_off();
  endtask

  task automatic t_back_to_back();
    logic [7:0] r0, r1;
    logic a, b, c;
    set_mode(1'b1, 1'b0);
    cs_on();
    do_write(5'd12, 1'b0, 8'hC3, 8'h00);
    do_read(5'd12, 1'b0, r0, r1, a, b, c);
    chk("R8 read right after write", {8'h0, r0}, 16'h00C3);
    do_write(5'd13, 1'b0, 8'h5E, 8'h00);
    do_read(5'd13, 1'b1, r0, r1, a, b, c);
    chk("R8 R4 word read after write", {r0, r1}, 16'h5EC3);
    cs_off();
  endtask

  task automatic t_abort();
    logic [7:0] r0, r1, junk;
    logic a, b, c, r, p, q;
    set_mode(1'b1, 1'b0);
    cs_on();
    byte_io(ins(1'b0, 1'b0, 5'd3), junk, a, b, c);
    for (int i = 0; i < 4; i++) bit_cycle(1'b1, r, p, q);
    cs_off();
    cs_on();
    do_read(5'd3, 1'b0, r0, r1, a, b, c);
    chk("R9 partial write discarded", {8'h0, r0}, 16'h005A);
    for (int i = 0; i < 3; i++) bit_cycle(1'b1, r, p, q);
    cs_off();
    cs_on();
    do_read(5'd12, 1'b0, r0, r1, a, b, c);
    chk("R9 bit counter restarts", {8'h0, r0}, 16'h00C3);
    cs_off();
    set_mode(1'b1, 1'b1);
    cs_on();
    byte_io(ins(1'b1, 1'b0, 5'd14), junk, a, b, c);
    for (int i = 0; i < 3; i++) bit_cycle(1'b0, r, p, q);
    chk("R6 din_oe driving mid-read", {15'b0, din_oe}, 16'h1);
    cs_off();
    chk("R9 R6 abort releases din", {15'b0, din_oe}, 16'h0);
  endtask

  initial begin
    checks   = 0;
    errors   = 0;
    reported = 1'b0;
    rst_n    = 1'b0;
    cfg_rise_active = 1'b1;
    cfg_two_wire    = 1'b0;
    cs_n     = 1'b1;
    sclk     = 1'b0;
    host_din = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_single();
    t_word();
    t_falling();
    t_two_wire();
    t_back_to_back();
    t_abort();
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end
endmodule